// File: doc/BRIEF.md
# Multi-Channel 50%-Duty Clock Divider Bank

This block derives several operating clocks from one base clock. Each channel holds a 4-bit ratio code; its output runs at the base frequency divided by (code + 1), so ratios range from 1 to 16. Every output has an exact 50% duty cycle, odd ratios included. A counter clocked on the rising edge sets the first part of the high phase. For odd ratios, a copy of that level taken on the falling edge stretches the high phase by half a base period.

Ratio codes are written through a narrow register port. Two 16-bit registers carry two channels each, in 4-bit fields. A new code does not cut into the current output period: the channel finishes the period it is in, then starts the new ratio on its next rising output edge. The block has two synchronous resets. The operation reset restarts every divider but keeps the stored codes. The initialization reset also returns every code to 0, which means pass-through.

Top module: `clkdiv_bank`

## Requirements
- R1: A channel with code k (0..15) produces a clock of period (k+1) base cycles whose high phase lasts exactly (k+1) base half-periods and whose low phase lasts the same, for both odd and even ratios.
- R2: Code 0 passes the base clock straight to the channel output (ratio 1).
- R3: Register 0 (`wr_sel`=0) holds channel 0 in bits [3:0] and channel 1 in bits [7:4]. Register 1 holds channel 2 in bits [3:0] and channel 3 in bits [7:4]. Bits [15:8] of either register are ignored.
- R4: Each channel's ratio is independent of the other channels' codes. A write to one register leaves the channels held in the other register unchanged.
- R5: A new code written in the middle of an output period takes effect only from the channel's next rising output edge. The period in progress completes at the old ratio.
- R6: An operation reset (`rst_op`) restarts the dividers and keeps the stored codes. Afterwards each channel resumes its previous ratio.
- R7: An initialization reset (`rst_init`) clears every stored code to 0. Afterwards every channel runs at ratio 1 until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock that all channels divide |
| rst_op | input | 1 | Synchronous active-high operation reset; stored codes are kept |
| rst_init | input | 1 | Synchronous active-high initialization reset; stored codes are cleared |
| wr_en | input | 1 | Register write strobe, sampled on the rising base edge |
| wr_sel | input | 1 | Selects ratio register 0 or 1 |
| wr_data | input | 16 | Register write data (two 4-bit channel fields in the low byte) |
| clk_out | output | 4 | One divided clock per channel |

## Verification
The bench samples every output once per base half-period and measures the lengths of its high and low runs. It sweeps all sixteen codes on every channel, and in each step it gives the four channels different codes. This catches off-by-one ratios, a missing half-period stretch on odd ratios, a wrong pass-through, and fields that bleed into each other. The upper data bits carry changing junk throughout, to show they are ignored. A write in the middle of a period shows whether the new ratio waits for the next rising edge. Two reset scenarios, a code-preserving operation reset followed by a clearing initialization reset, show how long the codes are retained.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SET_W = 4;
  localparam int REG_W = 16;
  localparam int CH_PER_REG = 2;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int NCH  = 4,
  parameter int SW   = 4,
  parameter int RW   = 16,
  parameter int CPR  = 2,
  parameter int SELW = 1
) (
  input  logic              clk,
  input  logic              rst_init,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [RW-1:0]     wr_data,
  output logic [NCH*SW-1:0] set_flat
);
  // one field per channel; only the strong reset clears them
  for (genvar c = 0; c < NCH; c++) begin : g_field
    localparam int REG_IDX = c / CPR;
    localparam int SLOT    = c % CPR;
    logic [SW-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst_init) begin
        code_q <= '0;
      end else if (wr_en && (int'(wr_sel) == REG_IDX)) begin
        code_q <= wr_data[SLOT*SW +: SW];
      end
    end
    assign set_flat[c*SW +: SW] = code_q;
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] code_i,
  output logic          clk_o,
  output logic [SW-1:0] act_o,
  output logic [SW-1:0] cnt_o
);
  logic [SW-1:0] cnt_q, act_q;
  logic          hi_r, hi_f;
  logic [SW:0]   half_new, half_act, cnt_nxt;

  // high-phase length in whole base cycles = floor(ratio/2)
  assign half_new = ({1'b0, code_i} + 1'b1) >> 1;
  assign half_act = ({1'b0, act_q}  + 1'b1) >> 1;
  assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= code_i;
      hi_r  <= (half_new != '0);
    end else if (cnt_q == act_q) begin
      // period boundary: the only point where a new code is adopted
      cnt_q <= '0;
      act_q <= code_i;
      hi_r  <= (half_new != '0);
    end else begin
      cnt_q <= cnt_q + 1'b1;
      hi_r  <= (cnt_nxt < half_act);
    end
  end

  // odd ratio: stretch the high phase by half a base period
  always_ff @(negedge clk) begin
    if (rst) hi_f <= 1'b0;
    else     hi_f <= hi_r & ~act_q[0];
  end

  assign clk_o = (act_q == '0) ? clk : (hi_r | hi_f);
  assign act_o = act_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SW   = SET_W,
  parameter int RW   = REG_W,
  parameter int CPR  = CH_PER_REG,
  parameter int NREG = (NCH + CPR - 1) / CPR,
  parameter int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk_base,
  input  logic            rst_op,
  input  logic            rst_init,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [RW-1:0]   wr_data,
  output logic [NCH-1:0]  clk_out
);
  logic [NCH*SW-1:0] set_all, act_all, cnt_all;
  logic              div_rst;

  assign div_rst = rst_op | rst_init;

  clkdiv_regs #(.NCH(NCH), .SW(SW), .RW(RW), .CPR(CPR), .SELW(SELW)) regs_i (
    .clk      (clk_base),
    .rst_init (rst_init),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .set_flat (set_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] code_in;
    // on the strong reset the divider restarts at the cleared code
    assign code_in = rst_init ? '0 : set_all[c*SW +: SW];
    clkdiv_chan #(.SW(SW)) chan_i (
      .clk    (clk_base),
      .rst    (div_rst),
      .code_i (code_in),
      .clk_o  (clk_out[c]),
      .act_o  (act_all[c*SW +: SW]),
      .cnt_o  (cnt_all[c*SW +: SW])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NCH = 4,
  parameter int SW  = 4
) (
  input logic              clk,
  input logic              rst_op,
  input logic              rst_init,
  input logic              wr_en,
  input logic [NCH*SW-1:0] set_all,
  input logic [NCH*SW-1:0] act_all,
  input logic [NCH*SW-1:0] cnt_all
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst_init) armed <= 1'b1;

  // R7
  init_clears_chk: assert property (@(posedge clk) disable iff (!armed)
    rst_init |=> (set_all == '0));

  // R6
  op_keeps_chk: assert property (@(posedge clk) disable iff (!armed || rst_init)
    (rst_op && !wr_en) |=> $stable(set_all));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R5
    adopt_at_edge_chk: assert property (@(posedge clk)
      disable iff (!armed || rst_op || rst_init)
      !$stable(act_all[c*SW +: SW]) |-> (cnt_all[c*SW +: SW] == '0));

    // R1
    cnt_in_range_chk: assert property (@(posedge clk)
      disable iff (!armed || rst_op || rst_init)
      cnt_all[c*SW +: SW] <= act_all[c*SW +: SW]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NCH(NCH), .SW(SW)) chk_i (
  .clk      (clk_base),
  .rst_op   (rst_op),
  .rst_init (rst_init),
  .wr_en    (wr_en),
  .set_all  (set_all),
  .act_all  (act_all),
  .cnt_all  (cnt_all)
);

// File: tb/clkdiv_bank_tb_top.sv
module clkdiv_bank_tb_top;
  localparam int NCH = 4;

  logic        clk_base = 1'b0;
  logic        rst_op = 1'b0, rst_init = 1'b0, wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  clk_out;

  int n_chk = 0, n_bad = 0;
  int runlen [NCH][8];
  int nrun   [NCH];
  int cur    [NCH];
  logic prv  [NCH];
  int code_e [NCH];

  always #10 clk_base = ~clk_base;

  clkdiv_bank dut_i (
    .clk_base (clk_base),
    .rst_op   (rst_op),
    .rst_init (rst_init),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .clk_out  (clk_out)
  );

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at posedge+5; stays aligned there
  task automatic wr(int sel, logic [15:0] d);
    wr_sel = sel[0:0]; wr_data = d; wr_en = 1'b1;
    @(posedge clk_base); #5;
    wr_en = 1'b0; wr_data = $urandom;
  endtask

  task automatic set_all_codes(int a, int b, int c, int d);
    logic [7:0] junk0, junk1;
    junk0 = 8'($urandom); junk1 = 8'($urandom);
    wr(0, {junk0, 4'(b), 4'(a)});   // R3: upper byte is junk
    wr(1, {junk1, 4'(d), 4'(c)});
    code_e[0] = a; code_e[1] = b; code_e[2] = c; code_e[3] = d;
  endtask

  task automatic idle(int cyc);
    repeat (cyc) begin @(posedge clk_base); #5; end
  endtask

  // sample every half-period, record complete run lengths
  task automatic collect(int halves);
    for (int c = 0; c < NCH; c++) begin
      nrun[c] = -1; cur[c] = 0; prv[c] = clk_out[c];
    end
    for (int k = 0; k < halves; k++) begin
      #10;
      for (int c = 0; c < NCH; c++) begin
        if (clk_out[c] != prv[c]) begin
          if (nrun[c] >= 0 && nrun[c] < 8) runlen[c][nrun[c]] = cur[c];
          nrun[c]++; cur[c] = 1;
        end else cur[c]++;
        prv[c] = clk_out[c];
      end
    end
    if (halves % 2 == 1) #10;
  endtask

  task automatic check_runs(string req);
    for (int c = 0; c < NCH; c++) begin
      int bad = 0;
      int lim = (nrun[c] > 8) ? 8 : nrun[c];
      for (int i = 0; i < lim; i++)
        if (runlen[c][i] != code_e[c] + 1) bad = runlen[c][i];
      check({req, " run count"}, (lim >= 2) ? 1 : 0, 1);
      check({req, " half-period run"}, (bad == 0) ? code_e[c] + 1 : bad, code_e[c] + 1);
    end
  endtask

  initial begin
    @(posedge clk_base); #5;
    rst_init = 1'b1; idle(3); rst_init = 1'b0;

    // R2 R7: reset state is ratio 1 everywhere
    for (int c = 0; c < NCH; c++) code_e[c] = 0;
    idle(4); collect(40); check_runs("R2/R7 reset state");

    // R1 R3 R4: exhaustive code sweep, distinct codes per channel
    for (int v = 0; v < 16; v++) begin
      set_all_codes(v, 15 - v, (v + 5) % 16, (v * 7) % 16);
      idle(40); collect(140); check_runs("R1/R3/R4 sweep");
    end

    // R4: rewriting register 1 leaves channels 0/1 alone
    set_all_codes(4, 9, 2, 2);
    wr(1, 16'hA5_3B); code_e[2] = 4'hB; code_e[3] = 4'h3;
    idle(40); collect(140); check_runs("R4 other register");

    // R5: change in mid-period finishes old period first
    begin
      int rl[4];
      int nr, cc;
      logic p, o;
      set_all_codes(7, 1, 1, 1);
      idle(40);
      p = clk_out[0];
      forever begin
        #10; o = clk_out[0];
        if (!p && o) break;
        p = o;
      end
      if ($time % 20 != 15) #10;   // keep to posedge+5 alignment
      wr_sel = '0; wr_data = 16'h0012; wr_en = 1'b1;  // ch0 -> code 2
      nr = 0; cc = 1; p = 1'b1;
      for (int k = 0; k < 60 && nr < 4; k++) begin
        #10;
        if (k == 1) begin wr_en = 1'b0; wr_data = $urandom; end
        o = clk_out[0];
        if (o != p) begin rl[nr] = cc; nr++; cc = 1; end else cc++;
        p = o;
      end
      check("R5 old high", rl[0], 8);
      check("R5 old low", rl[1], 8);
      check("R5 new high", rl[2], 3);
      check("R5 new low", rl[3], 3);
      if ($time % 20 != 15) #10;
      code_e[0] = 2;
    end

    // R6: operation reset keeps codes
    set_all_codes(3, 6, 11, 0);
    idle(20);
    rst_op = 1'b1; idle(2); rst_op = 1'b0;
    idle(4); collect(140); check_runs("R6 after op reset");

    // R7: init reset clears codes
    rst_init = 1'b1; idle(2); rst_init = 1'b0;
    for (int c = 0; c < NCH; c++) code_e[c] = 0;
    idle(4); collect(40); check_runs("R7 after init reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule